// File: doc/BRIEF.md
# Sector Address Header Writer

This block turns a sector's volume, track and sector numbers into the serial write stream for one address header on a floppy track. A single start pulse begins a run. The block first looks at the write-protect input. If the medium is protected, it writes nothing and reports an error. Otherwise it writes a gap of self-sync bytes, then the 14-byte header. The header is a three-byte opening mark, four odd-even encoded values (each taking two bytes) and a three-byte closing mark.

Time is divided into bit cells of `CELL_CLKS` clocks. A sync byte takes ten cells and a header byte takes eight. Bits are written most significant first. A one bit is a flip of the write line at the first clock edge of its cell. A zero bit leaves the line unchanged. The values are captured at start, so the caller may change its inputs while a run is in progress.

Top module: `addr_hdr_writer`

## Requirements
- R1: If `wp` is high when a start is accepted, `wr_data` does not change and `busy` stays low. `done` pulses in the next cycle and `err` is set and stays set.
- R2: The gap holds `sync_cnt` bytes, captured at start. Each gap byte is ten cells: eight cells carrying a one, then two cells carrying a zero (pattern 10'b1111111100). With `sync_cnt` = 0 the header starts at once.
- R3: Each cell lasts `CELL_CLKS` clocks. The first cell begins in the cycle after the start edge. `wr_data` toggles only at the first edge of a cell that carries a one, and never at any other time.
- R4: After the gap, the header opens with the bytes 8'hD5, 8'hAA, 8'h96, each eight cells and MSB first.
- R5: Volume, track, sector and checksum follow, in that order. Each value v is sent as two bytes: first {1,v[7],1,v[5],1,v[3],1,v[1]}, then {1,v[6],1,v[4],1,v[2],1,v[0]}.
- R6: The checksum value is volume XOR track XOR sector.
- R7: The header closes with 8'hDE, 8'hAA, 8'hEB. This makes 14 header bytes of eight cells each.
- R8: After reset `wr_data`, `busy`, `done` and `err` are low. On an accepted write, `busy` is high from the cycle after the start edge until the last cell ends. `done` is a single-cycle pulse in the cycle where `busy` has just fallen, (10·S+112)·CELL_CLKS cycles after the start edge.
- R9: An accepted start with `wp` low clears `err`, and `err` stays low through the write.
- R10: While `busy` is high, the inputs `start`, `wp`, `vol`, `trk`, `sec` and `sync_cnt` have no effect on the stream, on `err` or on the end of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a header (accepted when idle) |
| wp | input | 1 | Write-protect sense, sampled at start |
| vol | input | 8 | Volume number |
| trk | input | 8 | Track number |
| sec | input | 8 | Sector number |
| sync_cnt | input | SYNC_W | Number of self-sync bytes before the header |
| wr_data | output | 1 | Serial write line (a toggle means a one) |
| busy | output | 1 | Header run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last start was refused because of write protect |

## Verification
The bench builds the block with `CELL_CLKS` = 3 and `SYNC_W` = 8. With an odd cell length, legal toggles fall on a three-clock spacing, so an off-by-one in the cell counter or the bit counter shows up as a stray or missing flip. The gap counts used are 0, 1, 2, 5 and 40. They exercise the jump straight into the header, a single gap byte, and the hand-over from sync bytes to header bytes at different gap sizes. The chosen field values make every checksum bit and both halves of the encoding visible.

// File: rtl/addr_hdr_pkg.sv
package addr_hdr_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_SYNC, PH_HDR} phase_t;

  localparam int SYNC_CELLS = 10;
  localparam int HDR_CELLS  = 8;
  localparam int HDR_BYTES  = 14;

  // first byte of a pair: odd bits of the value, gaps filled with ones
  function automatic logic [7:0] oe_first(input logic [7:0] v);
    return (v >> 1) | 8'hAA;
  endfunction

  // second byte of a pair: even bits of the value
  function automatic logic [7:0] oe_second(input logic [7:0] v);
    return v | 8'hAA;
  endfunction

  function automatic logic [7:0] hdr_cksum(input logic [7:0] v, input logic [7:0] t,
                                           input logic [7:0] s);
    return v ^ t ^ s;
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [3:0] idx, input logic [7:0] v,
                                          input logic [7:0] t, input logic [7:0] s);
    logic [7:0] ck;
    ck = hdr_cksum(v, t, s);
    case (idx)
      4'd0:    return 8'hD5;
      4'd1:    return 8'hAA;
      4'd2:    return 8'h96;
      4'd3:    return oe_first(v);
      4'd4:    return oe_second(v);
      4'd5:    return oe_first(t);
      4'd6:    return oe_second(t);
      4'd7:    return oe_first(s);
      4'd8:    return oe_second(s);
      4'd9:    return oe_first(ck);
      4'd10:   return oe_second(ck);
      4'd11:   return 8'hDE;
      4'd12:   return 8'hAA;
      4'd13:   return 8'hEB;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ahw_cell_timer.sv
module ahw_cell_timer #(
  parameter int CELL_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic cell_start,
  output logic cell_end
);
  localparam int CNT_W = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign cell_start = en && (cnt == '0);
  assign cell_end   = en && (cnt == LAST);
endmodule

// File: rtl/ahw_seq.sv
module ahw_seq
  import addr_hdr_pkg::*;
#(
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wp,
  input  logic [7:0]        vol,
  input  logic [7:0]        trk,
  input  logic [7:0]        sec,
  input  logic [SYNC_W-1:0] sync_cnt,
  input  logic              cell_end,
  output phase_t            phase,
  output logic [3:0]        bit_idx,
  output logic [3:0]        hdr_idx,
  output logic [7:0]        v_q,
  output logic [7:0]        t_q,
  output logic [7:0]        s_q,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [3:0] SYNC_LAST = 4'(SYNC_CELLS - 1);
  localparam logic [3:0] HDR_LAST  = 4'(HDR_CELLS - 1);
  localparam logic [3:0] BYTE_LAST = 4'(HDR_BYTES - 1);

  logic [SYNC_W-1:0] sync_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_idx   <= '0;
      hdr_idx   <= '0;
      sync_left <= '0;
      v_q       <= '0;
      t_q       <= '0;
      s_q       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          if (wp) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            err       <= 1'b0;
            v_q       <= vol;
            t_q       <= trk;
            s_q       <= sec;
            sync_left <= sync_cnt;
            bit_idx   <= '0;
            hdr_idx   <= '0;
            phase     <= (sync_cnt == '0) ? PH_HDR : PH_SYNC;
          end
        end
        PH_SYNC: if (cell_end) begin
          if (bit_idx == SYNC_LAST) begin
            bit_idx <= '0;
            if (sync_left == SYNC_W'(1)) phase <= PH_HDR;
            else                         sync_left <= sync_left - 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        PH_HDR: if (cell_end) begin
          if (bit_idx == HDR_LAST) begin
            bit_idx <= '0;
            if (hdr_idx == BYTE_LAST) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R8

  AST_HDR_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR) |-> (hdr_idx <= BYTE_LAST)); // R7
endmodule

// File: rtl/ahw_line.sv
module ahw_line (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic bit_one,
  output logic wr
);
  logic flip_ev;
  assign flip_ev = cell_start && bit_one;

  always_ff @(posedge clk) begin
    if (!rst_n)       wr <= 1'b0;
    else if (flip_ev) wr <= ~wr;
  end
endmodule

// File: rtl/addr_hdr_writer.sv
module addr_hdr_writer
  import addr_hdr_pkg::*;
#(
  parameter int CELL_CLKS = 4,
  parameter int SYNC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wp,
  input  logic [7:0]        vol,
  input  logic [7:0]        trk,
  input  logic [7:0]        sec,
  input  logic [SYNC_W-1:0] sync_cnt,
  output logic              wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  phase_t     phase;
  logic [3:0] bit_idx, hdr_idx;
  logic [7:0] v_q, t_q, s_q;
  logic       cell_start, cell_end;
  logic [7:0] cur_hdr;
  logic       sync_bit, hdr_bit, bit_one;

  ahw_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(busy),
    .cell_start(cell_start), .cell_end(cell_end)
  );

  ahw_seq #(.SYNC_W(SYNC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wp(wp),
    .vol(vol), .trk(trk), .sec(sec), .sync_cnt(sync_cnt),
    .cell_end(cell_end), .phase(phase), .bit_idx(bit_idx), .hdr_idx(hdr_idx),
    .v_q(v_q), .t_q(t_q), .s_q(s_q), .busy(busy), .done(done), .err(err)
  );

  // sync cells 0..7 carry ones, 8..9 zeros; header bytes MSB first
  assign sync_bit = !bit_idx[3];
  assign cur_hdr  = hdr_byte(hdr_idx, v_q, t_q, s_q);
  assign hdr_bit  = cur_hdr[~bit_idx[2:0]];
  assign bit_one  = (phase == PH_SYNC) ? sync_bit :
                    (phase == PH_HDR)  ? hdr_bit  : 1'b0;

  ahw_line u_line (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .bit_one(bit_one), .wr(wr_data)
  );

  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && wp) |=> (done && err && !busy)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(wr_data)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_ERR_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !err); // R9
endmodule

// File: tb/sim_addr_hdr_writer.sv
module sim_addr_hdr_writer;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 3;
  localparam int SW = 8;
  localparam int MAXJ = 8192;

  logic clk, rst_n, start, wp;
  logic [7:0] vol, trk, sec;
  logic [SW-1:0] sync_cnt;
  logic wr_data, busy, done, err;

  int n_chk = 0, n_bad = 0;
  bit wv[MAXJ], bv[MAXJ], dv[MAXJ], ev[MAXJ];

  addr_hdr_writer #(.CELL_CLKS(CELL), .SYNC_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wp(wp), .vol(vol), .trk(trk),
    .sec(sec), .sync_cnt(sync_cnt), .wr_data(wr_data), .busy(busy),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // value v as two bytes, odd bits then even bits, gaps set to one
  function automatic logic [7:0] pair_byte(input logic [7:0] v, input bit second);
    if (!second) return {1'b1, v[7], 1'b1, v[5], 1'b1, v[3], 1'b1, v[1]};
    else         return {1'b1, v[6], 1'b1, v[4], 1'b1, v[2], 1'b1, v[0]};
  endfunction

  function automatic logic [7:0] exp_hdr(input int i, input logic [7:0] v,
                                         input logic [7:0] t, input logic [7:0] s);
    logic [7:0] marks [6];
    logic [7:0] vals [4];
    marks = '{8'hD5, 8'hAA, 8'h96, 8'hDE, 8'hAA, 8'hEB};
    vals  = '{v, t, s, v ^ t ^ s};
    if (i < 3)  return marks[i];
    if (i > 10) return marks[i - 8];
    return pair_byte(vals[(i - 3) / 2], ((i - 3) % 2) == 1);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; wp = 1'b0;
    vol = '0; trk = '0; sec = '0; sync_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !wr_data, "R8 reset state", {busy, done, err, wr_data}, 0);
  endtask

  task automatic t_protect();
    bit w0;
    @(negedge clk);
    vol = 8'h12; trk = 8'h05; sec = 8'h03; sync_cnt = 8'd4; wp = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w0 = wr_data;
    chk(done == 1'b1, "R1 done pulse after refused start", done, 1);
    chk(err == 1'b1, "R1 err set", err, 1);
    chk(busy == 1'b0, "R1 busy stays low", busy, 0);
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b1, "R1 done single, err held", {done, err}, 2'b01);
    for (int j = 0; j < 60 * CELL; j++) begin
      @(negedge clk);
      if (busy || wr_data != w0) begin
        chk(0, "R1 line quiet when protected", {busy, wr_data}, {1'b0, w0});
        break;
      end
    end
    chk(err == 1'b1, "R1 err persists", err, 1);
    wp = 1'b0;
  endtask

  task automatic t_write(input logic [7:0] v, input logic [7:0] t, input logic [7:0] s,
                         input int S, input bit disturb);
    int N, L, stray, bad_busy, bad_done, bad_err;
    logic [9:0] sb;
    logic [7:0] hb, eb;
    string tag;
    N = 10 * S + 112;
    L = N * CELL;
    @(negedge clk);
    vol = v; trk = t; sec = s; sync_cnt = SW'(S); wp = 1'b0; start = 1'b1;
    for (int j = 0; j <= L + 1; j++) begin
      @(negedge clk);
      if (j == 0) start = 1'b0;
      wv[j] = wr_data; bv[j] = busy; dv[j] = done; ev[j] = err;
      if (disturb && j == 5) begin
        wp = 1'b1; start = 1'b1; vol = ~v; trk = ~t; sec = ~s; sync_cnt = '0;
      end
      if (disturb && j == 6) start = 1'b0;
    end
    wp = 1'b0; start = 1'b0;

    chk(ev[0] == 1'b0, "R9 err cleared by accepted start", ev[0], 0);
    for (int b = 0; b < S; b++) begin
      for (int i = 0; i < 10; i++) begin
        int k = b * 10 + i;
        sb[9 - i] = wv[1 + k * CELL] ^ wv[k * CELL];
      end
      chk(sb == 10'b1111111100, "R2 sync byte", sb, 10'b1111111100);
    end
    for (int h = 0; h < 14; h++) begin
      for (int i = 0; i < 8; i++) begin
        int k = 10 * S + 8 * h + i;
        hb[7 - i] = wv[1 + k * CELL] ^ wv[k * CELL];
      end
      eb = exp_hdr(h, v, t, s);
      tag = (h < 3) ? "R4 start mark" : (h < 9) ? "R5 field pair" :
            (h < 11) ? "R6 checksum pair" : "R7 end mark";
      chk(hb == eb, tag, hb, eb);
    end
    stray = 0;
    for (int j = 1; j <= L + 1; j++) begin
      bit legal;
      legal = (j % CELL == 1 % CELL) && (j <= 1 + (N - 1) * CELL);
      if (!legal && wv[j] != wv[j - 1]) stray++;
    end
    chk(stray == 0, "R3 toggles only at cell starts", stray, 0);
    bad_busy = 0; bad_done = 0; bad_err = 0;
    for (int j = 0; j < L; j++) begin
      if (!bv[j]) bad_busy++;
      if (dv[j]) bad_done++;
      if (ev[j]) bad_err++;
    end
    chk(bad_busy == 0 && !bv[L], "R8 busy window", bad_busy, 0);
    chk(bad_done == 0 && dv[L] && !dv[L + 1], "R8 done timing", {dv[L], dv[L + 1]}, 2'b10);
    chk(bad_err == 0, "R9 err low during write", bad_err, 0);
    if (disturb)
      chk(!ev[L] && !bv[L + 1], "R10 inputs ignored while busy", {ev[L], bv[L + 1]}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_write(8'hFE, 8'h11, 8'h03, 2, 1'b0);
    t_protect();
    t_write(8'h55, 8'h22, 8'h0F, 0, 1'b0);
    t_write(8'hFF, 8'h22, 8'h0F, 5, 1'b1);
    t_write(8'h00, 8'hA5, 8'h3C, 1, 1'b0);
    t_write(8'h01, 8'h80, 8'h7F, 40, 1'b0);
    summary();
    $finish;
  end
endmodule